// File: doc/BRIEF.md
# Serial Port Interrupt Mask and Status Unit

This block gathers the event pulses of a serial port peripheral into one interrupt request. There are thirteen pulse inputs, and they come from the transmit path, the receive path and the modem-signal logic. Each pulse sets a sticky status bit. A mask selects which status bits may raise the request line. The request line is the registered OR of every status bit that is also enabled in the mask.

Software reaches the unit over a plain 32-bit register port. One write-only address enables mask bits and another write-only address disables them. A third address reads the mask back. The status address reads the raw sticky bits, and a write of ones to it clears those bits. To shut the unit down fully, software writes all thirteen ones to the disable address and then to the status address.

Top module: `uirq_ctrl`

## Requirements
- R1: The register port decodes byte offsets 0x08 (mask enable, write-only), 0x0C (mask disable, write-only), 0x10 (mask view, read-only) and 0x14 (status). Reads of the mask view and the status return the stored bits in [12:0]. Bits [31:13] of every read are zero. A read at any other offset returns zero.
- R2: A write to 0x08 sets each mask bit whose data bit is 1, starting at the clock edge of the write.
- R3: A write to 0x0C clears each mask bit whose data bit is 1, starting at the clock edge of the write.
- R4: Data bits that are 0 in a write to 0x08 or 0x0C leave the matching mask bits unchanged. Data bits [31:13] are ignored.
- R5: A one-cycle pulse on evt_pulse[i] sets status bit i at the next edge, whatever the mask holds. The bit stays set after the pulse ends. The fixed bit order is: 0 receive threshold, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full, 5 receive overflow, 6 framing error, 7 parity error, 8 receive timeout, 9 modem line change, 10 transmit threshold, 11 transmit almost full, 12 transmit overflow.
- R6: A write to 0x14 clears each status bit whose data bit is 1. Status bits whose data bit is 0 are kept.
- R7: When an event pulse and a status clear hit the same bit in the same cycle, the bit ends up set.
- R8: irq_out is a register. After each edge it holds the OR over all bits of (status AND mask) as they stood before that edge, so it follows a change in status or mask one cycle later.
- R9: Reset clears the mask and the status and drives irq_out low.
- R10: A write of 0x1FFF to 0x0C followed by a write of 0x1FFF to 0x14 leaves the mask and the status at zero and irq_out low.
- R11: A write to the read-only mask view at 0x10 changes neither the mask nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe for the register port, one cycle per write |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, decoded combinationally from reg_addr |
| evt_pulse | input | 13 | Event pulses, one bit per source |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The assertions assume that one write strobe carries a single decoded offset, so an enable and a disable never occur in the same cycle. They also assume that the event pulses and the strobe are stable around the rising edge. The bench drives every input on the falling edge and holds the strobe for exactly one cycle. It applies event pulses one source at a time, except in the collision case, where a pulse and a clear are driven deliberately in the same cycle.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int unsigned SRC_COUNT = 13;
    localparam int unsigned OFS_W     = 8;

    // Byte offsets of the register port
    localparam logic [OFS_W-1:0] OFS_MASK_SET  = 8'h08;
    localparam logic [OFS_W-1:0] OFS_MASK_CLR  = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_MASK_VIEW = 8'h10;
    localparam logic [OFS_W-1:0] OFS_STATUS    = 8'h14;

    // Source bit positions (software decodes these)
    typedef enum int unsigned {
        SRC_RX_THRESH   = 0,
        SRC_RX_EMPTY    = 1,
        SRC_RX_FULL     = 2,
        SRC_TX_EMPTY    = 3,
        SRC_TX_FULL     = 4,
        SRC_RX_OVERFLOW = 5,
        SRC_FRAME_ERR   = 6,
        SRC_PARITY_ERR  = 7,
        SRC_RX_IDLE_TO  = 8,
        SRC_LINE_CHANGE = 9,
        SRC_TX_THRESH   = 10,
        SRC_TX_ALMOST   = 11,
        SRC_TX_OVERFLOW = 12
    } src_bit_e;

endpackage

// File: rtl/uirq_mask_reg.sv
module uirq_mask_reg #(
    parameter int unsigned NUM_SRC = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_we,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] wr_bits,
    output logic [NUM_SRC-1:0] mask_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
    } mask_state_t;

    mask_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (set_we) begin
            state_d.en = state_q.en | wr_bits;
        end else if (clr_we) begin
            state_d.en = state_q.en & ~wr_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mask_o = state_q.en;

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((mask_o & $past(wr_bits)) == $past(wr_bits))); // R2

    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((mask_o & $past(wr_bits)) == '0)); // R3

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(mask_o)); // R11

    AST_MASK_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we || clr_we) |=> ((($past(mask_o) ^ mask_o) & ~$past(wr_bits)) == '0)); // R4

endmodule

// File: rtl/uirq_status_reg.sv
module uirq_status_reg #(
    parameter int unsigned NUM_SRC = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] clr_bits,
    output logic [NUM_SRC-1:0] stat_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] flag;
    } stat_state_t;

    stat_state_t state_d, state_q;
    logic [NUM_SRC-1:0] clr_eff;

    // Per-bit next value: a clear request loses to an event in the same cycle
    for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
        assign clr_eff[b] = clr_we & clr_bits[b];
    end

    always_comb begin
        state_d      = state_q;
        state_d.flag = (state_q.flag & ~clr_eff) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign stat_o = state_q.flag;

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt_i) & ~stat_o) == '0)); // R7

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> (($past(stat_o) & ~stat_o) == '0)); // R5

    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((stat_o & $past(clr_bits) & ~$past(evt_i)) == '0)); // R6

endmodule

// File: rtl/uirq_irq_out.sv
module uirq_irq_out #(
    parameter int unsigned NUM_SRC = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] stat_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic               irq_o
);

    typedef struct packed {
        logic req;
    } irq_state_t;

    irq_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.req = |(stat_i & mask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_o = state_q.req;

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(stat_i & mask_i)))); // R8

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_i & mask_i) == '0) |=> !irq_o); // R10

endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
    import uirq_pkg::*;
#(
    parameter int unsigned NUM_SRC = SRC_COUNT,
    parameter int unsigned ADDR_W  = OFS_W,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_SRC-1:0] evt_pulse,
    output logic               irq_out
);

    localparam int unsigned PAD_W = DATA_W - NUM_SRC;

    logic               hit_set, hit_clr, hit_view, hit_stat;
    logic               set_we, clr_we, stat_clr_we;
    logic [NUM_SRC-1:0] wr_bits;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] stat_q;
    logic               unused_wdata_hi;

    assign hit_set  = (reg_addr == ADDR_W'(OFS_MASK_SET));
    assign hit_clr  = (reg_addr == ADDR_W'(OFS_MASK_CLR));
    assign hit_view = (reg_addr == ADDR_W'(OFS_MASK_VIEW));
    assign hit_stat = (reg_addr == ADDR_W'(OFS_STATUS));

    assign set_we      = reg_we & hit_set;
    assign clr_we      = reg_we & hit_clr;
    assign stat_clr_we = reg_we & hit_stat;

    assign wr_bits         = reg_wdata[NUM_SRC-1:0];
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_SRC];

    uirq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_we  (set_we),
        .clr_we  (clr_we),
        .wr_bits (wr_bits),
        .mask_o  (mask_q)
    );

    uirq_status_reg #(.NUM_SRC(NUM_SRC)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_pulse),
        .clr_we   (stat_clr_we),
        .clr_bits (wr_bits),
        .stat_o   (stat_q)
    );

    uirq_irq_out #(.NUM_SRC(NUM_SRC)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (stat_q),
        .mask_i (mask_q),
        .irq_o  (irq_out)
    );

    always_comb begin
        reg_rdata = '0;
        if (hit_view) begin
            reg_rdata = {{PAD_W{1'b0}}, mask_q};
        end else if (hit_stat) begin
            reg_rdata = {{PAD_W{1'b0}}, stat_q};
        end
    end

    AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_we, clr_we, stat_clr_we})); // R1

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:NUM_SRC] == '0); // R1

endmodule

// File: tb/uirq_ctrl_bench.sv
module uirq_ctrl_bench;

    localparam int NS = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NS-1:0] evt_pulse = '0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    uirq_ctrl u_uirq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_pulse (evt_pulse),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [NS-1:0] bits);
        @(negedge clk);
        evt_pulse = bits;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(8'h10, v); chk("R9 mask after reset", v, 32'h0);
        rd(8'h14, v); chk("R9 status after reset", v, 32'h0);
        chk("R9 irq after reset", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_mask;
        logic [31:0] v;
        wr(8'h08, 32'h0000_0005);
        rd(8'h10, v); chk("R2 enable sets bits", v, 32'h5);
        wr(8'h08, 32'h0000_0100);
        rd(8'h10, v); chk("R4 zero bits keep mask", v, 32'h105);
        wr(8'h08, 32'hFFFF_E000);
        rd(8'h10, v); chk("R4 upper data bits ignored", v, 32'h105);
        wr(8'h0C, 32'h0000_0004);
        rd(8'h10, v); chk("R3 disable clears bit", v, 32'h101);
        wr(8'h10, 32'h0000_1FFF);
        rd(8'h10, v); chk("R11 mask view write ignored (mask)", v, 32'h101);
        rd(8'h14, v); chk("R11 mask view write ignored (status)", v, 32'h0);
        @(negedge clk);
        chk("R8 masked bits but no status gives no irq", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_events;
        logic [31:0] v;
        logic [NS-1:0] acc;
        acc = '0;
        for (int i = 0; i < NS; i++) begin
            pulse(NS'(1) << i);
            acc = acc | (NS'(1) << i);
            rd(8'h14, v); chk($sformatf("R5 sticky status after source %0d", i), v, {19'b0, acc});
            if (i == 0) begin
                chk("R8 irq lags status by one cycle", {31'b0, irq_out}, 32'h0);
                @(negedge clk);
                chk("R8 irq rises one cycle after status", {31'b0, irq_out}, 32'h1);
            end
        end
    endtask

    task automatic t_clear;
        logic [31:0] v;
        wr(8'h14, 32'h0000_0001);
        rd(8'h14, v); chk("R6 write one clears status bit", v, 32'h1FFE);
        @(negedge clk);
        chk("R8 irq stays with bit 8 pending", {31'b0, irq_out}, 32'h1);
        wr(8'h14, 32'h0000_0100);
        rd(8'h14, v); chk("R6 second clear", v, 32'h1EFE);
        chk("R8 irq still high one cycle after clear", {31'b0, irq_out}, 32'h1);
        @(negedge clk);
        chk("R8 irq falls when no enabled status", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'h14; reg_wdata = 32'h0000_0018;
        evt_pulse = 13'h0008;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0; evt_pulse = '0;
        rd(8'h14, v); chk("R7 event beats same-cycle clear", v, 32'h1EEE);
    endtask

    task automatic t_quiesce;
        logic [31:0] v;
        wr(8'h08, 32'h0000_1FFF);
        @(negedge clk);
        chk("R8 irq with all enabled", {31'b0, irq_out}, 32'h1);
        wr(8'h0C, 32'h0000_1FFF);
        wr(8'h14, 32'h0000_1FFF);
        rd(8'h10, v); chk("R10 mask zero after quiesce", v, 32'h0);
        rd(8'h14, v); chk("R10 status zero after quiesce", v, 32'h0);
        @(negedge clk);
        chk("R10 irq low after quiesce", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_decode;
        logic [31:0] v;
        wr(8'h08, 32'h0000_0003);
        pulse(13'h1000);
        rd(8'h00, v); chk("R1 unmapped offset reads zero", v, 32'h0);
        rd(8'h08, v); chk("R1 enable offset is write-only", v, 32'h0);
        rd(8'h0C, v); chk("R1 disable offset is write-only", v, 32'h0);
        rd(8'h10, v); chk("R1 mask view", v, 32'h3);
        rd(8'h14, v); chk("R1 status view", v, 32'h1000);
        wr(8'h20, 32'h0000_1FFF);
        rd(8'h14, v); chk("R1 write to unmapped offset ignored", v, 32'h1000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_events();
        t_clear();
        t_collide();
        t_quiesce();
        t_decode();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule